// File: doc/BRIEF.md
# Segment Table Invalidation Engine

This block keeps a small table of segment translation entries and removes stale ones on command. Software writes a 64-bit command word naming an effective segment ID, a class bit, a segment size and a qualifier. For every table entry whose tags agree with the command, the engine clears the entry's valid bit. The qualifier can widen the match so that the partition ID and the process ID must also agree. Those two IDs come from a separate selection register, which is written before the command.

Commands wait in a small in-order queue. The engine compares one table entry per clock, so each command takes one full sweep of the table. A read of the status word returns the queue capacity and the number of commands not yet finished. Software polls this count until it reaches zero to know that its invalidations have taken effect. A load port fills or overwrites table entries. If a load and a clear target the same entry in the same cycle, the load wins.

Top module: `seg_inval_engine`

## Requirements
- R1: The command word is numbered MSB-first (bit 0 is data bit 63). Data bits [63:28] carry the segment ID, bit [27] the class, bits [26:25] the size and bits [1:0] the qualifier. Bits [24:2] are ignored.
- R2: A command clears an entry only if the entry is valid and its segment ID, class and size all equal the command's. An entry that differs in any one of these stays valid.
- R3: With qualifier 00, partition and process IDs take no part in the match.
- R4: With qualifier 01, the entry's partition ID must also equal the selection value, and the process ID is ignored.
- R5: With qualifier 11, both the partition ID and the process ID must equal the selection values.
- R6: A command with qualifier 10 is accepted and counted but clears no entry.
- R7: The status read holds the queue capacity (4) in data bits [39:32] and the pending count in bits [7:0]. All other bits read zero.
- R8: The pending count rises by one on the edge that accepts a command. It falls 16 cycles later, after the sweep compares entries 0 to 15, one per clock.
- R9: A command written while the pending count equals 4 is dropped. The count stays at 4 and the table is untouched.
- R10: Queued commands run in arrival order. Each command uses the selection values held when it was written, even if the selection register changes later.
- R11: After reset, every table entry is invalid and the pending count is 0.
- R12: A load writes all fields of the addressed entry, including its valid bit, and the result shows on the valid vector one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wr_data | input | 64 | Command word |
| sel_wr_en | input | 1 | Selection register write strobe |
| sel_lpid_in | input | 12 | Partition ID for qualified matches |
| sel_pid_in | input | 16 | Process ID for qualified matches |
| stat_rd_data | output | 64 | Status word: capacity and pending count |
| ld_en | input | 1 | Entry load strobe |
| ld_idx | input | 4 | Entry index to load |
| ld_valid | input | 1 | Valid bit to load |
| ld_esid | input | 36 | Segment ID to load |
| ld_cls | input | 1 | Class bit to load |
| ld_ss | input | 2 | Segment size to load |
| ld_lpid | input | 12 | Partition ID to load |
| ld_pid | input | 16 | Process ID to load |
| entry_valid | output | 16 | Valid bit of every table entry |

## Verification
The assertions assume the load port stays quiet while a sweep runs. They also assume the selection register is never written in the same cycle as a command, so the value captured with a command is unambiguous. The bench keeps to this rule. It reloads the whole table only while the pending count is zero, and it writes the selection register and the command on separate edges. Overflow and ordering are exercised by back-to-back command writes, which the engine must accept or drop with no outside pacing.

// File: rtl/seg_inval_pkg.sv
package seg_inval_pkg;
    localparam int ESID_W = 36;
    localparam int LPID_W = 12;
    localparam int PID_W  = 16;
    localparam int SS_W   = 2;
    localparam int IQ_W   = 2;

    localparam logic [IQ_W-1:0] IQ_ANY   = 2'b00;
    localparam logic [IQ_W-1:0] IQ_LP    = 2'b01;
    localparam logic [IQ_W-1:0] IQ_RSVD  = 2'b10;
    localparam logic [IQ_W-1:0] IQ_LPPID = 2'b11;

    typedef struct packed {
        logic [ESID_W-1:0] esid;
        logic              cls;
        logic [SS_W-1:0]   ss;
        logic [IQ_W-1:0]   iq;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
    } inval_cmd_t;

    typedef struct packed {
        logic              valid;
        logic [ESID_W-1:0] esid;
        logic              cls;
        logic [SS_W-1:0]   ss;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
    } seg_entry_t;
endpackage

// File: rtl/seg_cmd_fifo.sv
module seg_cmd_fifo
    import seg_inval_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  inval_cmd_t       push_cmd,
    input  logic             pop_en,
    output inval_cmd_t       head_cmd,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        inval_cmd_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]       wr;
        logic [PTR_W-1:0]       rd;
        logic [CNT_W-1:0]       cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     accept;
    logic     take;

    always_comb begin
        st_d   = st_q;
        accept = push_en && (st_q.cnt != CNT_W'(DEPTH));
        take   = pop_en && (st_q.cnt != '0);
        if (accept) begin
            st_d.slot[st_q.wr] = push_cmd;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (take) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(accept) - CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_cmd = st_q.slot[st_q.rd];
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R9
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(DEPTH) && push_en && !pop_en) |=> (st_q.cnt == CNT_W'(DEPTH))); // R9
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (st_q.cnt != '0)); // R8
endmodule

// File: rtl/seg_entry_table.sv
module seg_entry_table
    import seg_inval_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_idx,
    input  seg_entry_t         ld_entry,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output seg_entry_t         rd_entry,
    output logic [ENTRIES-1:0] valid_vec
);
    typedef struct packed {
        seg_entry_t [ENTRIES-1:0] ent;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.ent[clr_idx].valid = 1'b0;
        if (ld_en)  st_d.ent[ld_idx] = ld_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_entry = st_q.ent[rd_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = st_q.ent[g].valid;
    end

    AST_CLEAR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(ld_en && ld_idx == clr_idx)) |=> !valid_vec[$past(clr_idx)]); // R2
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (valid_vec[$past(ld_idx)] == $past(ld_entry.valid))); // R12
endmodule

// File: rtl/seg_sweep_ctrl.sv
module seg_sweep_ctrl
    import seg_inval_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  inval_cmd_t       head_cmd,
    input  seg_entry_t       cur_entry,
    output logic [IDX_W-1:0] scan_idx,
    output logic             clr_en,
    output logic             pop_en
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } sweep_st_t;

    sweep_st_t st_d, st_q;
    logic      tag_hit;
    logic      qual_hit;
    logic      at_last;

    always_comb begin
        st_d    = st_q;
        tag_hit = cur_entry.valid
               && (cur_entry.esid == head_cmd.esid)
               && (cur_entry.cls  == head_cmd.cls)
               && (cur_entry.ss   == head_cmd.ss);
        unique case (head_cmd.iq)
            IQ_ANY:   qual_hit = 1'b1;
            IQ_LP:    qual_hit = (cur_entry.lpid == head_cmd.lpid);
            IQ_LPPID: qual_hit = (cur_entry.lpid == head_cmd.lpid)
                              && (cur_entry.pid == head_cmd.pid);
            default:  qual_hit = 1'b0;
        endcase
        at_last = (st_q.idx == IDX_W'(ENTRIES - 1));
        clr_en  = !q_empty && tag_hit && qual_hit;
        pop_en  = !q_empty && at_last;
        if (q_empty || at_last) st_d.idx = '0;
        else                    st_d.idx = st_q.idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan_idx = st_q.idx;

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (scan_idx == '0)); // R8
    AST_RSVD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (head_cmd.iq == IQ_RSVD) |-> !clr_en); // R6
    AST_LP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && head_cmd.iq == IQ_LP) |-> (cur_entry.lpid == head_cmd.lpid)); // R4
    AST_PID_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && head_cmd.iq == IQ_LPPID) |-> (cur_entry.pid == head_cmd.pid)); // R5
endmodule

// File: rtl/seg_inval_engine.sv
module seg_inval_engine
    import seg_inval_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int QDEPTH  = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr_en,
    input  logic [63:0]        cmd_wr_data,
    input  logic               sel_wr_en,
    input  logic [LPID_W-1:0]  sel_lpid_in,
    input  logic [PID_W-1:0]   sel_pid_in,
    output logic [63:0]        stat_rd_data,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic               ld_valid,
    input  logic [ESID_W-1:0]  ld_esid,
    input  logic               ld_cls,
    input  logic [SS_W-1:0]    ld_ss,
    input  logic [LPID_W-1:0]  ld_lpid,
    input  logic [PID_W-1:0]   ld_pid,
    output logic [ENTRIES-1:0] entry_valid
);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
    } sel_st_t;

    sel_st_t    sel_d, sel_q;
    inval_cmd_t new_cmd;
    inval_cmd_t head_cmd;
    seg_entry_t ld_entry;
    seg_entry_t cur_entry;
    logic       q_empty;
    logic       pop_en;
    logic       clr_en;
    logic [IDX_W-1:0] scan_idx;
    logic [CNT_W-1:0] pending;

    always_comb begin
        sel_d = sel_q;
        if (sel_wr_en) begin
            sel_d.lpid = sel_lpid_in;
            sel_d.pid  = sel_pid_in;
        end
        new_cmd.esid = cmd_wr_data[63:28];
        new_cmd.cls  = cmd_wr_data[27];
        new_cmd.ss   = cmd_wr_data[26:25];
        new_cmd.iq   = cmd_wr_data[1:0];
        new_cmd.lpid = sel_q.lpid;
        new_cmd.pid  = sel_q.pid;
        ld_entry = '{valid: ld_valid, esid: ld_esid, cls: ld_cls,
                     ss: ld_ss, lpid: ld_lpid, pid: ld_pid};
        stat_rd_data        = '0;
        stat_rd_data[39:32] = 8'(QDEPTH);
        stat_rd_data[7:0]   = 8'(pending);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    seg_cmd_fifo #(.DEPTH(QDEPTH), .CNT_W(CNT_W)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_en(cmd_wr_en), .push_cmd(new_cmd),
        .pop_en(pop_en), .head_cmd(head_cmd),
        .empty(q_empty), .count(pending)
    );

    seg_entry_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_entry(ld_entry),
        .clr_en(clr_en), .clr_idx(scan_idx),
        .rd_idx(scan_idx), .rd_entry(cur_entry),
        .valid_vec(entry_valid)
    );

    seg_sweep_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_sweep (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .head_cmd(head_cmd), .cur_entry(cur_entry),
        .scan_idx(scan_idx), .clr_en(clr_en), .pop_en(pop_en)
    );

    AST_PENDING_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_en && pending != CNT_W'(QDEPTH) && !pop_en)
            |=> (pending == $past(pending) + 1'b1)); // R8
    AST_PENDING_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !cmd_wr_en) |=> (pending == $past(pending) - 1'b1)); // R8
endmodule

// File: tb/test_seg_inval_engine.sv
`timescale 1ns/1ps
module test_seg_inval_engine;
    localparam logic [35:0] ESID_A = 36'hABC_DE12_3;
    localparam logic [35:0] ESID_B = 36'h123_4567_0;

    typedef struct packed {
        logic [35:0] esid;
        logic        cls;
        logic [1:0]  ss;
        logic [1:0]  iq;
        logic        resv_ones;
        logic [11:0] lpid;
        logic [15:0] pid;
        logic [15:0] exp_mask;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{ESID_A,          1'b0, 2'd0, 2'b00, 1'b0, 12'd0, 16'd0,  16'hFF46, 8'd3},  // R3
        '{ESID_A,          1'b0, 2'd0, 2'b01, 1'b0, 12'd1, 16'd0,  16'hFF6E, 8'd4},  // R4
        '{ESID_A,          1'b0, 2'd0, 2'b11, 1'b0, 12'd1, 16'd10, 16'hFF7E, 8'd5},  // R5
        '{ESID_A,          1'b0, 2'd0, 2'b10, 1'b0, 12'd1, 16'd10, 16'hFFFF, 8'd6},  // R6
        '{ESID_A,          1'b1, 2'd0, 2'b00, 1'b0, 12'd0, 16'd0,  16'hFFFD, 8'd2},  // R2
        '{ESID_A,          1'b0, 2'd1, 2'b00, 1'b0, 12'd0, 16'd0,  16'hFFFB, 8'd2},  // R2
        '{ESID_A ^ 36'd1,  1'b0, 2'd0, 2'b00, 1'b0, 12'd0, 16'd0,  16'hFFBF, 8'd2},  // R2
        '{ESID_B + 36'd9,  1'b0, 2'd0, 2'b00, 1'b1, 12'd0, 16'd0,  16'hFDFF, 8'd1},  // R1
        '{ESID_A,          1'b0, 2'd0, 2'b11, 1'b0, 12'd2, 16'd11, 16'hFFDF, 8'd5},  // R5
        '{ESID_A,          1'b0, 2'd0, 2'b01, 1'b0, 12'd2, 16'd0,  16'hFFD7, 8'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [63:0] cmd_wr_data = '0;
    logic        sel_wr_en = 1'b0;
    logic [11:0] sel_lpid_in = '0;
    logic [15:0] sel_pid_in = '0;
    logic [63:0] stat_rd_data;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic        ld_valid = 1'b0;
    logic [35:0] ld_esid = '0;
    logic        ld_cls = 1'b0;
    logic [1:0]  ld_ss = '0;
    logic [11:0] ld_lpid = '0;
    logic [15:0] ld_pid = '0;
    logic [15:0] entry_valid;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seg_inval_engine i_seg_inval_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .sel_wr_en(sel_wr_en), .sel_lpid_in(sel_lpid_in), .sel_pid_in(sel_pid_in),
        .stat_rd_data(stat_rd_data),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_valid(ld_valid), .ld_esid(ld_esid),
        .ld_cls(ld_cls), .ld_ss(ld_ss), .ld_lpid(ld_lpid), .ld_pid(ld_pid),
        .entry_valid(entry_valid)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic load_one(input int i, input logic v);
        ld_en    = 1'b1;
        ld_idx   = 4'(i);
        ld_valid = v;
        ld_esid  = (i < 8) ? ESID_A : ESID_B + 36'(i);
        ld_cls   = (i == 1);
        ld_ss    = (i == 2) ? 2'd1 : 2'd0;
        ld_lpid  = (i == 3 || i == 5) ? 12'd2 : 12'd1;
        ld_pid   = (i == 4 || i == 5) ? 16'd11 : 16'd10;
        if (i == 6) ld_esid = ESID_A ^ 36'd1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_std();
        for (int i = 0; i < 16; i++) load_one(i, 1'b1);
    endtask

    task automatic sel_write(input logic [11:0] lp, input logic [15:0] pd);
        sel_wr_en = 1'b1; sel_lpid_in = lp; sel_pid_in = pd;
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic cmd_write(input logic [35:0] es, input logic c, input logic [1:0] s,
                             input logic [1:0] q, input logic rsv);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = {es, c, s, {23{rsv}}, q};
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset valid", 64'(entry_valid), 64'h0);
        check("R7 R11 reset status", stat_rd_data, 64'h0000_0004_0000_0000);

        load_std();
        check("R12 loaded valid", 64'(entry_valid), 64'hFFFF);
        load_one(3, 1'b0);
        check("R12 load clears valid", 64'(entry_valid), 64'hFFF7);

        for (int v = 0; v < NVEC; v++) begin
            load_std();
            sel_write(VECS[v].lpid, VECS[v].pid);
            cmd_write(VECS[v].esid, VECS[v].cls, VECS[v].ss, VECS[v].iq, VECS[v].resv_ones);
            wait_cycles(16);
            n_checks++;
            if (entry_valid !== VECS[v].exp_mask || stat_rd_data[7:0] !== 8'd0) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: got mask %h pend %0d expected mask %h pend 0",
                         VECS[v].req, v, entry_valid, stat_rd_data[7:0], VECS[v].exp_mask);
            end
        end

        // R8 sweep timing
        load_std();
        cmd_write(ESID_A, 1'b0, 2'd0, 2'b10, 1'b0);
        check("R8 pending after accept", 64'(stat_rd_data[7:0]), 64'd1);
        wait_cycles(15);
        check("R8 pending mid sweep", 64'(stat_rd_data[7:0]), 64'd1);
        wait_cycles(1);
        check("R8 pending after sweep", 64'(stat_rd_data[7:0]), 64'd0);

        // R9 overflow drop
        load_std();
        for (int k = 0; k < 4; k++) cmd_write(ESID_A, 1'b0, 2'd0, 2'b10, 1'b0);
        cmd_write(ESID_B + 36'd9, 1'b0, 2'd0, 2'b00, 1'b0);
        check("R9 R7 status when full", stat_rd_data, 64'h0000_0004_0000_0004);
        wait_cycles(80);
        check("R9 dropped command no effect", 64'(entry_valid), 64'hFFFF);
        check("R9 pending drained", 64'(stat_rd_data[7:0]), 64'd0);

        // R10 ordering and captured selection
        load_std();
        sel_write(12'd1, 16'd10);
        cmd_write(ESID_A, 1'b0, 2'd0, 2'b11, 1'b0);
        sel_write(12'd2, 16'd11);
        cmd_write(ESID_A, 1'b0, 2'd0, 2'b11, 1'b0);
        wait_cycles(14);
        check("R10 first done only", {48'd0, entry_valid}, 64'hFF7E);
        check("R10 one still pending", 64'(stat_rd_data[7:0]), 64'd1);
        wait_cycles(16);
        check("R10 both done", 64'(entry_valid), 64'hFF5E);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule